// File: doc/BRIEF.md
# Parallel EEPROM Write Capture

This block is the device-side write path of a 32-bit-wide parallel EEPROM model. Three active-low control pins (chip select, write enable, output enable) arrive with no timing relation to the system clock. The block resamples them, together with the address and data buses, through two flip-flop stages. It then decides when a write strobe opens and closes. A write strobe counts as open while chip select and write enable are both low. The address is taken at the moment the strobe opens, which is the later of the two falling edges. The data word is taken at the moment it closes, which is the earlier of the two rising edges.

Captured words collect in a small page buffer. Every falling edge of write enable restarts a page-window one-shot. When that window runs out, the buffered words are copied into an internal register file in one step. A `busy` output then stays high for a fixed programming period, and any write activity during that period is ignored. The window and programming lengths are parameters counted in clock cycles. A combinational look-up port reads the register file, so the stored contents can be observed.

Top module: `eeprom_wr_capture`

## Requirements
- R1: After a synchronous reset, `busy` is low and every register-file word reads as zero.
- R2: A write is accepted only if output enable is high (`out_en_n` = 1) at the moment chip select and write enable first become low together. A strobe that opens with `out_en_n` low stores nothing.
- R3: The address stored is the value present when the strobe opens. Address changes while the strobe stays open are ignored. This holds whether write enable or chip select is the later of the two to fall.
- R4: The data stored is the value present when the strobe closes, which is the first of chip select or write enable to return high. Data changes before that moment, or after it, have no effect.
- R5: Each falling edge of write enable loads the page timer with `PAGE_CYC`. A further falling edge before the timer expires restarts it from the full value, even when no write accompanies that edge.
- R6: When the page window expires with at least one buffered word, all buffered words are written to the register file in that same edge. `busy` is then high for exactly `PROG_CYC` cycles. An expiry with an empty buffer raises no `busy`. Before expiry, the register file keeps its old contents.
- R7: A write to an address that is already in the page buffer replaces that entry's data. The last value written is the one committed.
- R8: Once `PAGE_WORDS` distinct addresses are buffered, writes to a new address are dropped. Writes to addresses already buffered still take effect.
- R9: While `busy` is high, write strobes and write-enable falling edges are ignored. They store nothing and start no page window.
- R10: A pin change takes effect at the third rising clock edge after it (two synchronizer stages plus the decision register). For this reason `busy` rises `PAGE_CYC + 3` edges after the last write-enable fall. Expiry is held off while a strobe is still open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_sel_n | input | 1 | Asynchronous active-low chip select |
| wr_en_n | input | 1 | Asynchronous active-low write enable |
| out_en_n | input | 1 | Asynchronous active-low output enable; must be high when a write opens |
| addr | input | AW | Word address bus |
| data | input | DW | Write data bus |
| rd_addr | input | AW | Register-file look-up address |
| rd_data | output | DW | Register-file word at `rd_addr` (combinational) |
| busy | output | 1 | High during the internal programming period |

## Verification
The capture edges are exercised with both strobe orderings. In one, chip select falls first and write enable gates the pulse. In the other, write enable falls first and chip select gates it. In both, the address and data buses change inside the open strobe and again after the first rising edge, so a design that samples on the wrong edge stores the wrong word or the wrong address. Page handling is covered by four patterns: repeated addresses, more distinct addresses than the buffer holds, a bare write-enable pulse that only restarts the window, and writes issued while busy. The bench's cycle model separates an off-by-one latency or programming length from a correct one. A strobe that opens while output enable is low separates gating on the opening moment from no gating at all.

// File: rtl/ewc_pkg.sv
// Package ewc_pkg
// Shared constants and types for the EEPROM write-capture block.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package ewc_pkg;

    // Number of flip-flop stages used to resample asynchronous pins.
    localparam int unsigned SYNC_STAGES = 2;

    // State of the write strobe tracker.
    typedef enum logic {
        STB_IDLE = 1'b0,
        STB_HELD = 1'b1
    } stb_state_e;

endpackage

// File: rtl/ewc_sync.sv
// Module ewc_sync
// Multi-stage resampling register for a bus of W bits. Used both as a
// metastability synchronizer for control pins and as a matching delay for
// the address and data buses, so all pins reach the decision logic aligned.
// Assumes the buses are held stable around the control edges for longer than
// the stage count in clock cycles.
module ewc_sync #(
    parameter int unsigned      W       = 1,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    import ewc_pkg::*;

    logic [W-1:0] stg [SYNC_STAGES];

    // Shift the input through the resampling stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(SYNC_STAGES); i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(SYNC_STAGES); i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[SYNC_STAGES-1];

endmodule

// File: rtl/ewc_strobe.sv
// Module ewc_strobe
// Decides when a write strobe opens and closes from the resampled control
// pins. The strobe is open while select and write enable are both low; it is
// accepted only if output enable is high and the device is idle at the
// opening moment. Address is held from the opening, data is presented at the
// closing. Also flags every falling edge of write enable.
// Assumes inputs are already synchronous to clk.
module ewc_strobe #(
    parameter int unsigned AW = 7,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_s_n,
    input  logic          wen_s_n,
    input  logic          oen_s_n,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    input  logic          busy,
    output logic          we_fall,
    output logic          wr_done,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          active
);
    import ewc_pkg::*;

    stb_state_e    state_q;
    logic          both_low_q;
    logic          wen_q;
    logic [AW-1:0] addr_q;
    logic          both_low;
    logic          open_ev;

    // Combine the pins and find the open/close moments.
    always_comb begin
        both_low = !sel_s_n && !wen_s_n;
        open_ev  = both_low && !both_low_q && oen_s_n && !busy;
        wr_done  = !both_low && both_low_q && (state_q == STB_HELD);
        we_fall  = wen_q && !wen_s_n;
    end

    // Track the previous pin state, the strobe state and the held address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            both_low_q <= 1'b0;
            wen_q      <= 1'b1;
            state_q    <= STB_IDLE;
            addr_q     <= '0;
        end else begin
            both_low_q <= both_low;
            wen_q      <= wen_s_n;
            if (wr_done) begin
                state_q <= STB_IDLE;
            end else if (open_ev) begin
                state_q <= STB_HELD;
                addr_q  <= addr_s;
            end
        end
    end

    assign wr_addr = addr_q;
    assign wr_data = data_s;
    assign active  = (state_q == STB_HELD);

    // R2
    open_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> ($past(oen_s_n) && !$past(busy)));

    // R4
    close_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !active);

endmodule

// File: rtl/ewc_page.sv
// Module ewc_page
// Page buffer, retriggerable page-window timer and programming-period
// counter. Completed writes are merged into the buffer (same address
// overwrites, new addresses fill free slots, overflow is dropped). When the
// window expires with no strobe open, the buffer is handed to the register
// file in one cycle and busy is raised for PROG_CYC cycles.
// Assumes wr_done and we_fall are single-cycle pulses.
module ewc_page #(
    parameter int unsigned AW         = 7,
    parameter int unsigned DW         = 32,
    parameter int unsigned PAGE_WORDS = 4,
    parameter int unsigned PAGE_CYC   = 15000,
    parameter int unsigned PROG_CYC   = 600000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_fall,
    input  logic                           wr_done,
    input  logic [AW-1:0]                  wr_addr,
    input  logic [DW-1:0]                  wr_data,
    input  logic                           strobe_active,
    output logic                           busy,
    output logic                           commit,
    output logic [PAGE_WORDS-1:0]          ent_vld,
    output logic [PAGE_WORDS-1:0][AW-1:0]  ent_addr,
    output logic [PAGE_WORDS-1:0][DW-1:0]  ent_data
);
    localparam int unsigned TW = $clog2(PAGE_CYC + 1);
    localparam int unsigned BW = $clog2(PROG_CYC + 1);
    localparam int unsigned IW = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;

    logic [TW-1:0]                 timer_q;
    logic [BW-1:0]                 prog_q;
    logic [PAGE_WORDS-1:0]         vld_q;
    logic [PAGE_WORDS-1:0][AW-1:0] addr_q;
    logic [PAGE_WORDS-1:0][DW-1:0] data_q;

    logic          hit;
    logic [IW-1:0] hit_idx;
    logic          has_free;
    logic [IW-1:0] free_idx;
    logic          expire;

    // Look up the incoming address and the lowest free slot.
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        has_free = 1'b0;
        free_idx = '0;
        for (int i = 0; i < int'(PAGE_WORDS); i++) begin
            if (vld_q[i] && (addr_q[i] == wr_addr)) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
        for (int i = int'(PAGE_WORDS) - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                has_free = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    // Window end: idle, timer on its last count, no strobe open, no retrigger.
    always_comb begin
        busy   = (prog_q != '0);
        expire = !busy && (timer_q == TW'(1)) && !strobe_active && !we_fall;
        commit = expire && (|vld_q);
    end

    // Advance timers and merge completed writes into the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
            prog_q  <= '0;
            vld_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (busy) begin
            prog_q <= prog_q - BW'(1);
        end else if (expire) begin
            timer_q <= '0;
            vld_q   <= '0;
            if (commit) prog_q <= BW'(PROG_CYC);
        end else begin
            if (we_fall) begin
                timer_q <= TW'(PAGE_CYC);
            end else if (timer_q > TW'(1)) begin
                timer_q <= timer_q - TW'(1);
            end
            if (wr_done) begin
                if (hit) begin
                    data_q[hit_idx] <= wr_data;
                end else if (has_free) begin
                    vld_q[free_idx]  <= 1'b1;
                    addr_q[free_idx] <= wr_addr;
                    data_q[free_idx] <= wr_data;
                end
            end
        end
    end

    assign ent_vld  = vld_q;
    assign ent_addr = addr_q;
    assign ent_data = data_q;

    // R6
    busy_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (vld_q == '0));

    // R6
    prog_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (prog_q == $past(prog_q) - BW'(1)));

    // R5
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_fall && !busy) |=> (timer_q == TW'(PAGE_CYC)));

    // R9
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(timer_q) && $stable(vld_q)));

endmodule

// File: rtl/ewc_array.sv
// Module ewc_array
// Register file of 2**AW words. On commit every valid page entry is written
// to its word in parallel; a combinational port reads any word.
// Assumes page entries carry distinct addresses.
module ewc_array #(
    parameter int unsigned AW         = 7,
    parameter int unsigned DW         = 32,
    parameter int unsigned PAGE_WORDS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           commit,
    input  logic [PAGE_WORDS-1:0]          ent_vld,
    input  logic [PAGE_WORDS-1:0][AW-1:0]  ent_addr,
    input  logic [PAGE_WORDS-1:0][DW-1:0]  ent_data,
    input  logic [AW-1:0]                  rd_addr,
    output logic [DW-1:0]                  rd_data
);
    localparam int unsigned WORDS = 1 << AW;

    logic [WORDS-1:0][DW-1:0] words;

    for (genvar w = 0; w < int'(WORDS); w++) begin : g_word
        logic [DW-1:0] word_q;

        // Store the matching page entry into this word on commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (commit) begin
                for (int e = 0; e < int'(PAGE_WORDS); e++) begin
                    if (ent_vld[e] && (ent_addr[e] == AW'(w))) word_q <= ent_data[e];
                end
            end
        end

        assign words[w] = word_q;
    end

    assign rd_data = words[rd_addr];

    // R6
    array_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(words));

endmodule

// File: rtl/eeprom_wr_capture.sv
// Module eeprom_wr_capture
// Top of the parallel EEPROM write-capture front end: resamples the pins,
// tracks write strobes, buffers a page and commits it into a register file.
// Assumes address and data stay stable for at least two clock cycles around
// each control edge.
module eeprom_wr_capture #(
    parameter int unsigned AW         = 7,
    parameter int unsigned DW         = 32,
    parameter int unsigned PAGE_WORDS = 4,
    parameter int unsigned PAGE_CYC   = 15000,
    parameter int unsigned PROG_CYC   = 600000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_sel_n,
    input  logic          wr_en_n,
    input  logic          out_en_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          busy
);
    logic          sel_s_n, wen_s_n, oen_s_n;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] data_s;
    logic          we_fall, wr_done, strobe_active, commit;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [PAGE_WORDS-1:0]         ent_vld;
    logic [PAGE_WORDS-1:0][AW-1:0] ent_addr;
    logic [PAGE_WORDS-1:0][DW-1:0] ent_data;

    ewc_sync #(.W(3), .RST_VAL(3'b111)) u_ctrl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({chip_sel_n, wr_en_n, out_en_n}),
        .q({sel_s_n, wen_s_n, oen_s_n})
    );

    ewc_sync #(.W(AW + DW), .RST_VAL('0)) u_bus_dly (
        .clk(clk), .rst_n(rst_n),
        .d({addr, data}),
        .q({addr_s, data_s})
    );

    ewc_strobe #(.AW(AW), .DW(DW)) u_strobe (
        .clk(clk), .rst_n(rst_n),
        .sel_s_n(sel_s_n), .wen_s_n(wen_s_n), .oen_s_n(oen_s_n),
        .addr_s(addr_s), .data_s(data_s), .busy(busy),
        .we_fall(we_fall), .wr_done(wr_done),
        .wr_addr(wr_addr), .wr_data(wr_data), .active(strobe_active)
    );

    ewc_page #(
        .AW(AW), .DW(DW), .PAGE_WORDS(PAGE_WORDS),
        .PAGE_CYC(PAGE_CYC), .PROG_CYC(PROG_CYC)
    ) u_page (
        .clk(clk), .rst_n(rst_n),
        .we_fall(we_fall), .wr_done(wr_done),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .strobe_active(strobe_active),
        .busy(busy), .commit(commit),
        .ent_vld(ent_vld), .ent_addr(ent_addr), .ent_data(ent_data)
    );

    ewc_array #(.AW(AW), .DW(DW), .PAGE_WORDS(PAGE_WORDS)) u_array (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .ent_vld(ent_vld), .ent_addr(ent_addr), .ent_data(ent_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

endmodule

// File: tb/eeprom_wr_capture_tb.sv
module eeprom_wr_capture_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 5;
    localparam int DW   = 32;
    localparam int PW   = 4;
    localparam int PAGE = 40;
    localparam int PROG = 100;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_sel_n = 1'b1, wr_en_n = 1'b1, out_en_n = 1'b1;
    logic [AW-1:0] addr = '0, rd_addr = '0;
    logic [DW-1:0] data = '0;
    logic [DW-1:0] rd_data;
    logic          busy;

    int n_chk = 0, n_err = 0;
    int cyc = 0, last_fall_cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    eeprom_wr_capture #(.AW(AW), .DW(DW), .PAGE_WORDS(PW),
                        .PAGE_CYC(PAGE), .PROG_CYC(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n),
        .out_en_n(out_en_n), .addr(addr), .data(data), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );

    // ---------------- behavioural reference model ----------------
    logic hc1 = 1, hc2 = 1, hc3 = 1, hw1 = 1, hw2 = 1, hw3 = 1, ho1 = 1, ho2 = 1;
    int   ha1 = 0, ha2 = 0, hd1 = 0, hd2 = 0;
    logic [DW-1:0] m_mem [WORDS];
    int   qa[$];
    logic [DW-1:0] qd[$];
    int   m_timer = 0, m_prog = 0, m_addr = 0;
    logic m_act = 0;

    always @(posedge clk) begin
        logic lowb, plow, wfall, bz, act_old, opn, cls, found;
        if (!rst_n) begin
            hc1 = 1; hc2 = 1; hc3 = 1; hw1 = 1; hw2 = 1; hw3 = 1; ho1 = 1; ho2 = 1;
            ha1 = 0; ha2 = 0; hd1 = 0; hd2 = 0;
            m_timer = 0; m_prog = 0; m_act = 0; m_addr = 0;
            qa.delete(); qd.delete();
            for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
        end else begin
            lowb  = !hc2 && !hw2;
            plow  = !hc3 && !hw3;
            wfall = hw3 && !hw2;
            bz    = (m_prog != 0);
            act_old = m_act;
            opn = lowb && !plow && ho2 && !bz;
            cls = !lowb && plow && m_act;
            if (cls) m_act = 0;
            else if (opn) begin m_act = 1; m_addr = ha2; end
            if (bz) m_prog--;
            else if (m_timer == 1 && !act_old && !wfall) begin
                foreach (qa[i]) m_mem[qa[i]] = qd[i];
                m_prog = (qa.size() > 0) ? PROG : 0;
                qa.delete(); qd.delete();
                m_timer = 0;
            end else begin
                if (wfall) m_timer = PAGE;
                else if (m_timer > 1) m_timer--;
                if (cls) begin
                    found = 0;
                    foreach (qa[i]) if (qa[i] == m_addr) begin qd[i] = DW'(hd2); found = 1; end
                    if (!found && qa.size() < PW) begin qa.push_back(m_addr); qd.push_back(DW'(hd2)); end
                end
            end
            hc3 = hc2; hw3 = hw2;
            hc2 = hc1; hw2 = hw1; ho2 = ho1; ha2 = ha1; hd2 = hd1;
            hc1 = chip_sel_n; hw1 = wr_en_n; ho1 = out_en_n; ha1 = int'(addr); hd1 = int'(data);
        end
    end

    // Compare busy with the model on every clock (R6, R10).
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (busy !== (m_prog != 0)) begin
                n_err++;
                $display("FAIL R6 R10 busy per-cycle at cyc %0d actual=%0b expected=%0b",
                         cyc, busy, (m_prog != 0));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [DW-1:0] v);
        @(negedge clk);
        rd_addr = AW'(a);
        #1 v = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Select low first, write enable gates; address and data disturbed around the edges.
    task automatic wr_we(input int a, input logic [DW-1:0] d, input int junk_a);
        @(negedge clk);
        chip_sel_n = 0; addr = AW'(a); data = ~d;
        idle(3);
        wr_en_n = 0; last_fall_cyc = cyc;
        idle(2);
        addr = AW'(junk_a); data = d;
        idle(2);
        wr_en_n = 1;
        idle(2);
        data = 32'hDEAD_BEEF;
        idle(2);
        chip_sel_n = 1;
        idle(3);
    endtask

    // Write enable low first, select gates; select rises before write enable.
    task automatic wr_cs(input int a, input logic [DW-1:0] d, input int junk_a);
        @(negedge clk);
        wr_en_n = 0; last_fall_cyc = cyc;
        idle(3);
        chip_sel_n = 0; addr = AW'(a); data = ~d;
        idle(2);
        addr = AW'(junk_a); data = d;
        idle(2);
        chip_sel_n = 1;
        idle(2);
        data = 32'h0BAD_F00D;
        idle(2);
        wr_en_n = 1;
        idle(3);
    endtask

    task automatic wait_busy_rise(input string req);
        int g = 0;
        while (!busy && g < 1000) begin @(negedge clk); g++; end
        chk(req, DW'(cyc - last_fall_cyc), DW'(PAGE + 3));
    endtask

    task automatic count_busy(input string req);
        int n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk(req, DW'(n), DW'(PROG));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // ---------------- directed scenarios ----------------
    initial begin
        logic [DW-1:0] v;
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset state
        chk("R1 busy after reset", DW'(busy), 0);
        rd(0, v);  chk("R1 word 0", v, 0);
        rd(31, v); chk("R1 word 31", v, 0);

        // R3 R4 both strobe orderings, R6 R10 commit timing
        wr_we(1, 32'h1111_0001, 6);
        wr_we(2, 32'h2222_0002, 7);
        wr_cs(3, 32'h3333_0003, 8);
        rd(1, v); chk("R6 no commit before expiry", v, 0);
        wait_busy_rise("R10 busy rise latency");
        count_busy("R6 busy length");
        rd(1, v); chk("R4 we-gated data", v, 32'h1111_0001);
        rd(2, v); chk("R4 data at first rise", v, 32'h2222_0002);
        rd(3, v); chk("R3 R4 select-gated", v, 32'h3333_0003);
        rd(6, v); chk("R3 late address ignored", v, 0);
        rd(8, v); chk("R3 late address ignored cs", v, 0);

        // R2 output enable low at opening
        out_en_n = 0;
        wr_we(7, 32'h7777_0007, 9);
        out_en_n = 1;
        idle(PAGE + 10);
        chk("R2 R6 no busy on empty page", DW'(busy), 0);
        rd(7, v); chk("R2 write blocked by output enable", v, 0);

        // R7 overwrite, R8 overflow
        wr_we(10, 32'hA0A0_0001, 10);
        wr_cs(11, 32'hB1B1_0011, 11);
        wr_we(12, 32'hC2C2_0012, 12);
        wr_we(13, 32'hD3D3_0013, 13);
        wr_we(14, 32'hE4E4_0014, 14);
        wr_cs(10, 32'hA0A0_0002, 10);
        wait_busy_rise("R10 busy rise after full page");
        count_busy("R6 busy length full page");
        rd(10, v); chk("R7 overwrite keeps last", v, 32'hA0A0_0002);
        rd(11, v); chk("R8 slot two", v, 32'hB1B1_0011);
        rd(13, v); chk("R8 slot four", v, 32'hD3D3_0013);
        rd(14, v); chk("R8 overflow dropped", v, 0);

        // R5 retrigger by a bare write-enable pulse
        wr_we(4, 32'h4444_0004, 4);
        idle(18);
        @(negedge clk);
        wr_en_n = 0; last_fall_cyc = cyc;
        idle(3);
        wr_en_n = 1;
        idle(30);
        chk("R5 window restarted", DW'(busy), 0);
        rd(4, v); chk("R5 not yet committed", v, 0);
        wait_busy_rise("R5 R10 rise after retrigger");
        count_busy("R6 busy length retrigger");
        rd(4, v); chk("R5 committed after window", v, 32'h4444_0004);

        // R9 activity while busy
        wr_we(15, 32'h5555_0015, 15);
        wait_busy_rise("R10 busy rise single");
        wr_we(20, 32'h6666_0020, 20);
        while (busy) @(negedge clk);
        idle(PAGE + 10);
        chk("R9 no window started while busy", DW'(busy), 0);
        rd(20, v); chk("R9 write during busy dropped", v, 0);
        rd(15, v); chk("R9 earlier page intact", v, 32'h5555_0015);

        // R6 whole register file against the model
        for (int a = 0; a < WORDS; a++) begin
            rd(a, v);
            chk($sformatf("R6 word %0d vs model", a), v, m_mem[a]);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule